// File: doc/BRIEF.md
# Register-Offset Random-Read Sequencer

This block runs a complete random read from a device on a two-wire serial bus. It does this by driving the register port of a separate byte-level bus engine. Software, or another block, supplies four things: a 7-bit device address, a 16-bit register offset, an offset width of one or two bytes, and a byte count. It then pulses `start`. From there the sequencer runs the whole exchange without further help. It resets and sets up the engine, issues a START, and writes the device address and the offset. It then issues a repeated START, reads the requested bytes and issues a STOP.

After every command that it writes to the engine's control register, the sequencer polls the engine's status register. It waits for exactly one expected status code, with a fixed spacing between reads and a bounded number of reads. Any other outcome ends the transfer at once: the error output pulses and carries the last status value that was read. Received bytes leave on a valid/data stream as each one is fetched. A successful transfer ends with a done pulse that carries the number of bytes delivered.

Top module: `regrd_sequencer`

## Requirements
- R1: After `start`, the first four bus writes are soft reset (register index 7), own address (index 0), extended own address (index 4) and divider (index 3), in that order. Each of the first three writes 0x00 and the divider write carries 0x24. The next write is control (index 2) = 0x40 (enable alone), expecting status 0xF8.
- R2: The next control write is 0x60 (START plus enable), expecting 0x08. The data register (index 1) is then written with the device address shifted left and bit 0 clear, followed by control 0x40, expecting 0x18.
- R3: With the two-byte offset width selected, the offset's high byte is written to the data register before its low byte. With the one-byte width, only the low byte is written. Each offset byte is followed by control 0x40, expecting 0x28.
- R4: Next comes control 0x60, expecting 0x10 (repeated START). The data register is then written with the shifted device address and bit 0 set, followed by control 0x40, expecting 0x40.
- R5: For a count N ≥ 1, N−1 reads use control 0x44 (acknowledge bit 0x04 set), each expecting 0x50. The final read uses control 0x40, expecting 0x58. After each accepted status, the data register is read and the byte appears on `rx_valid`/`rx_data`, in order. A count of 0 or 1 performs only the final read.
- R6: The transfer closes with control 0x50 (STOP plus enable), expecting 0xF8. Then `done` pulses for one cycle with `xfer_len` equal to the number of bytes delivered.
- R7: After each control write, the sequencer waits POLL_CLKS cycles and then reads the status register (index 3). It repeats this for up to POLL_TRIES reads, and the step succeeds on the first read that returns the expected code.
- R8: If none of the POLL_TRIES reads match, `err` pulses for one cycle with `err_stat` equal to the last status read. `done` stays low and no bus access follows until the next accepted `start`.
- R9: While `busy` is high, `start` is ignored. Address, offset, width and count are captured when a transfer is accepted, so later changes on those inputs have no effect on it.
- R10: `bus_wr` and `bus_rd` are never high together, and neither is high while `busy` is low. After reset, `busy`, `done`, `err` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| dev_addr | input | 7 | Device address |
| reg_off | input | 16 | Register offset inside the device |
| off_wide | input | 1 | 1: two offset bytes, 0: one |
| byte_cnt | input | CNT_W | Bytes to read (0 treated as 1) |
| busy | output | 1 | Transfer in progress |
| bus_wr | output | 1 | Engine register write strobe |
| bus_rd | output | 1 | Engine register read strobe |
| bus_addr | output | 3 | Engine register index |
| bus_wdata | output | 8 | Engine write data |
| bus_rdata | input | 8 | Engine read data, valid in the cycle of `bus_rd` |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| done | output | 1 | One-cycle success pulse |
| xfer_len | output | CNT_W | Bytes delivered, valid with `done` |
| err | output | 1 | One-cycle abort pulse |
| err_stat | output | 8 | Last status read, valid with `err` |

## Verification
The hardest cases to reach from the ports are the edges of the poll budget. In one, the expected code shows up on exactly the last permitted status read. In the other, it shows up one read too late. The bench's engine model therefore counts status reads instead of cycles: after each control write it returns a pending code for a chosen number of reads. Setting that number to POLL_TRIES−1 and then to POLL_TRIES puts the sequencer on each side of the boundary. The model can also inject a persistent wrong code at a chosen control write, which aborts the transfer mid-sequence so the bench can confirm that the bus then falls silent.

// File: rtl/regrd_pkg.sv
package regrd_pkg;

  // engine register indices (the engine decodes these)
  localparam logic [2:0] RA_OWN  = 3'd0;
  localparam logic [2:0] RA_DATA = 3'd1;
  localparam logic [2:0] RA_CTRL = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;  // read side
  localparam logic [2:0] RA_DIV  = 3'd3;  // write side
  localparam logic [2:0] RA_XOWN = 3'd4;
  localparam logic [2:0] RA_SRST = 3'd7;

  // control bits
  localparam logic [7:0] C_ACK   = 8'h04;
  localparam logic [7:0] C_STOP  = 8'h10;
  localparam logic [7:0] C_START = 8'h20;
  localparam logic [7:0] C_EN    = 8'h40;

  // status codes
  localparam logic [7:0] ST_IDLE   = 8'hF8;
  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK = 8'h18;
  localparam logic [7:0] ST_WD_ACK = 8'h28;
  localparam logic [7:0] ST_AR_ACK = 8'h40;
  localparam logic [7:0] ST_RD_ACK = 8'h50;
  localparam logic [7:0] ST_RD_NAK = 8'h58;

  typedef enum logic [3:0] {
    S_SRST, S_OWN, S_XOWN, S_DIV, S_EN, S_START, S_ADRW, S_OFFH,
    S_OFFL, S_RSTART, S_ADRR, S_RDACK, S_RDLAST, S_STOP
  } step_e;

  typedef struct packed {
    logic [2:0] pre_addr;
    logic [7:0] pre_val;
    logic       ctl_en;
    logic [7:0] ctl;
    logic [7:0] expect_st;
    logic       grab;
  } step_t;

  function automatic logic [7:0] divider_val(input logic [2:0] m, input logic [2:0] n);
    return {2'b00, m, n};
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

  // steps that start with a register write before any control write
  function automatic logic has_pre(input step_e s);
    return (s inside {S_SRST, S_OWN, S_XOWN, S_DIV, S_ADRW, S_OFFH, S_OFFL, S_ADRR});
  endfunction

endpackage

// File: rtl/regrd_poll.sv
module regrd_poll #(
  parameter int POLL_CLKS  = 1000,
  parameter int POLL_TRIES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic waiting,
  input  logic miss,
  output logic tick,
  output logic last_try
);
  localparam int IC_W = $clog2(POLL_CLKS + 1);
  localparam int AC_W = $clog2(POLL_TRIES + 1);

  logic [IC_W-1:0] ic_q;
  logic [AC_W-1:0] ac_q;

  assign tick     = waiting && (ic_q == IC_W'(POLL_CLKS - 1));
  assign last_try = (ac_q == AC_W'(POLL_TRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q <= '0;
      ac_q <= '0;
    end else begin
      if (clr) begin
        ic_q <= '0;
        ac_q <= '0;
      end else begin
        if (tick)         ic_q <= '0;
        else if (waiting) ic_q <= ic_q + 1'b1;
        if (miss)         ac_q <= ac_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/regrd_stepdec.sv
module regrd_stepdec
  import regrd_pkg::*;
(
  input  step_e       step,
  input  logic [6:0]  dev,
  input  logic [15:0] off,
  output step_t       d
);
  always_comb begin
    d = '0;
    unique case (step)
      S_SRST:   begin d.pre_addr = RA_SRST; d.pre_val = 8'h00; end
      S_OWN:    begin d.pre_addr = RA_OWN;  d.pre_val = 8'h00; end
      S_XOWN:   begin d.pre_addr = RA_XOWN; d.pre_val = 8'h00; end
      S_DIV:    begin d.pre_addr = RA_DIV;  d.pre_val = divider_val(3'd4, 3'd4); end
      S_EN:     begin d.ctl_en = 1'b1; d.ctl = C_EN;           d.expect_st = ST_IDLE;   end
      S_START:  begin d.ctl_en = 1'b1; d.ctl = C_START | C_EN; d.expect_st = ST_START;  end
      S_ADRW:   begin d.pre_addr = RA_DATA; d.pre_val = addr_byte(dev, 1'b0);
                      d.ctl_en = 1'b1; d.ctl = C_EN;           d.expect_st = ST_AW_ACK; end
      S_OFFH:   begin d.pre_addr = RA_DATA; d.pre_val = off[15:8];
                      d.ctl_en = 1'b1; d.ctl = C_EN;           d.expect_st = ST_WD_ACK; end
      S_OFFL:   begin d.pre_addr = RA_DATA; d.pre_val = off[7:0];
                      d.ctl_en = 1'b1; d.ctl = C_EN;           d.expect_st = ST_WD_ACK; end
      S_RSTART: begin d.ctl_en = 1'b1; d.ctl = C_START | C_EN; d.expect_st = ST_RSTART; end
      S_ADRR:   begin d.pre_addr = RA_DATA; d.pre_val = addr_byte(dev, 1'b1);
                      d.ctl_en = 1'b1; d.ctl = C_EN;           d.expect_st = ST_AR_ACK; end
      S_RDACK:  begin d.ctl_en = 1'b1; d.ctl = C_ACK | C_EN;   d.expect_st = ST_RD_ACK; d.grab = 1'b1; end
      S_RDLAST: begin d.ctl_en = 1'b1; d.ctl = C_EN;           d.expect_st = ST_RD_NAK; d.grab = 1'b1; end
      S_STOP:   begin d.ctl_en = 1'b1; d.ctl = C_STOP | C_EN;  d.expect_st = ST_IDLE;   end
      default:  d = '0;
    endcase
  end
endmodule

// File: rtl/regrd_sequencer.sv
module regrd_sequencer
  import regrd_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int POLL_CLKS  = 1000,
  parameter int POLL_TRIES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       dev_addr,
  input  logic [15:0]      reg_off,
  input  logic             off_wide,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             busy,
  output logic             bus_wr,
  output logic             bus_rd,
  output logic [2:0]       bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic [CNT_W-1:0] xfer_len,
  output logic             err,
  output logic [7:0]       err_stat
);
  typedef enum logic [2:0] {F_IDLE, F_PRE, F_CTRL, F_WAIT, F_STAT, F_DATA} fsm_e;

  fsm_e             st_q;
  step_e            step_q, nstep;
  logic             fin;
  logic [6:0]       dev_q;
  logic [15:0]      off_q;
  logic             wide_q;
  logic [CNT_W-1:0] acks_q, nrx_q;
  step_t            d;

  // named internal events (observed by the checker)
  logic poll_tick, poll_last, stat_hit, stat_miss, accept, advance;

  regrd_stepdec u_dec (.step(step_q), .dev(dev_q), .off(off_q), .d(d));

  regrd_poll #(.POLL_CLKS(POLL_CLKS), .POLL_TRIES(POLL_TRIES)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .clr(st_q == F_CTRL), .waiting(st_q == F_WAIT), .miss(stat_miss && !poll_last),
    .tick(poll_tick), .last_try(poll_last)
  );

  assign busy      = (st_q != F_IDLE);
  assign accept    = start && !busy;
  assign stat_hit  = (st_q == F_STAT) && (bus_rdata == d.expect_st);
  assign stat_miss = (st_q == F_STAT) && (bus_rdata != d.expect_st);
  assign advance   = ((st_q == F_PRE) && !d.ctl_en) || (stat_hit && !d.grab) || (st_q == F_DATA);

  // step ordering
  always_comb begin
    nstep = step_q;
    fin   = 1'b0;
    unique case (step_q)
      S_ADRW:  nstep = wide_q ? S_OFFH : S_OFFL;
      S_ADRR:  nstep = (acks_q == '0) ? S_RDLAST : S_RDACK;
      S_RDACK: nstep = (acks_q == CNT_W'(1)) ? S_RDLAST : S_RDACK;
      S_STOP:  fin   = 1'b1;
      default: nstep = step_e'(step_q + 4'd1);
    endcase
  end

  // bus drive
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = 3'd0;
    bus_wdata = 8'h00;
    unique case (st_q)
      F_PRE:   begin bus_wr = 1'b1; bus_addr = d.pre_addr; bus_wdata = d.pre_val; end
      F_CTRL:  begin bus_wr = 1'b1; bus_addr = RA_CTRL;    bus_wdata = d.ctl;     end
      F_STAT:  begin bus_rd = 1'b1; bus_addr = RA_STAT; end
      F_DATA:  begin bus_rd = 1'b1; bus_addr = RA_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= F_IDLE;
      step_q   <= S_SRST;
      dev_q    <= '0;
      off_q    <= '0;
      wide_q   <= 1'b0;
      acks_q   <= '0;
      nrx_q    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= 8'h00;
      done     <= 1'b0;
      xfer_len <= '0;
      err      <= 1'b0;
      err_stat <= 8'h00;
    end else begin
      rx_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (accept) begin
        dev_q  <= dev_addr;
        off_q  <= reg_off;
        wide_q <= off_wide;
        acks_q <= (byte_cnt == '0) ? '0 : byte_cnt - 1'b1;
        nrx_q  <= '0;
        step_q <= S_SRST;
        st_q   <= F_PRE;
      end
      unique case (st_q)
        F_PRE:  if (d.ctl_en) st_q <= F_CTRL;
        F_CTRL: st_q <= F_WAIT;
        F_WAIT: if (poll_tick) st_q <= F_STAT;
        F_STAT: begin
          if (stat_hit && d.grab) st_q <= F_DATA;
          else if (stat_miss) begin
            if (poll_last) begin
              err      <= 1'b1;
              err_stat <= bus_rdata;
              st_q     <= F_IDLE;
            end else st_q <= F_WAIT;
          end
        end
        F_DATA: begin
          rx_valid <= 1'b1;
          rx_data  <= bus_rdata;
          nrx_q    <= nrx_q + 1'b1;
        end
        default: ;
      endcase
      if (advance) begin
        if (step_q == S_RDACK) acks_q <= acks_q - 1'b1;
        if (fin) begin
          done     <= 1'b1;
          xfer_len <= nrx_q;
          st_q     <= F_IDLE;
        end else begin
          step_q <= nstep;
          st_q   <= has_pre(nstep) ? F_PRE : F_CTRL;
        end
      end
    end
  end
endmodule

// File: rtl/regrd_chk.sv
module regrd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic       rx_valid,
  input logic       done,
  input logic       err,
  input logic       stat_hit,
  input logic       poll_last
);
  p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_wr && !bus_rd));

  p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !bus_wr && !bus_rd));

  p_err_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(poll_last));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hit_is_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (bus_rd && bus_addr == 3'd3));

  p_poll_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3) |-> $past(!bus_wr && !bus_rd));

  p_rx_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done || err));
endmodule

bind regrd_sequencer regrd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .rx_valid(rx_valid), .done(done), .err(err),
  .stat_hit(stat_hit), .poll_last(poll_last)
);

// File: tb/regrd_sequencer_tb.sv
module regrd_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int PCLK  = 3;
  localparam int TRIES = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [15:0] reg_off = '0;
  logic off_wide = 1'b0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic busy, bus_wr, bus_rd, rx_valid, done, err;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rx_data, err_stat;
  logic [CNT_W-1:0] xfer_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  regrd_sequencer #(.CNT_W(CNT_W), .POLL_CLKS(PCLK), .POLL_TRIES(TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr), .reg_off(reg_off),
    .off_wide(off_wide), .byte_cnt(byte_cnt), .busy(busy), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .xfer_len(xfer_len),
    .err(err), .err_stat(err_stat)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------- engine model ----------
  logic [15:0] cur_off = '0;
  int lat_cfg = -1;            // -1: random 0..3 pending reads
  int inj_at = 0;              // control write number to corrupt (0 = none)
  logic [7:0] inj_code = 8'h00;
  logic [7:0] dreg, rbyte, code;
  int ms, reads_left, ctrl_cnt, ridx;

  function automatic logic [7:0] pat(input logic [15:0] off, input int i);
    return (off[7:0] + off[15:8] + 8'(i * 29)) ^ 8'h3C;
  endfunction

  assign bus_rdata = (bus_addr == 3'd3) ? ((reads_left > 0) ? 8'h00 : code)
                   : (bus_addr == 3'd1) ? rbyte : 8'h00;

  always @(posedge clk) begin
    if (start && !busy) begin
      ms <= 0; ctrl_cnt <= 0; ridx <= 0; reads_left <= 0; code <= 8'hF8;
    end else if (bus_wr && bus_addr == 3'd1) begin
      dreg <= bus_wdata;
    end else if (bus_wr && bus_addr == 3'd2) begin
      ctrl_cnt   <= ctrl_cnt + 1;
      reads_left <= (lat_cfg < 0) ? int'($urandom_range(0, 3)) : lat_cfg;
      if (inj_at != 0 && ctrl_cnt + 1 >= inj_at) code <= inj_code;
      else if (bus_wdata & 8'h10) begin code <= 8'hF8; ms <= 0; end
      else if (bus_wdata & 8'h20) begin code <= (ms == 0) ? 8'h08 : 8'h10; ms <= 1; end
      else if (ms == 0) code <= 8'hF8;
      else if (ms == 1) begin code <= dreg[0] ? 8'h40 : 8'h18; ms <= dreg[0] ? 3 : 2; end
      else if (ms == 2) code <= 8'h28;
      else begin
        code  <= (bus_wdata & 8'h04) ? 8'h50 : 8'h58;
        rbyte <= pat(cur_off, ridx);
        ridx  <= ridx + 1;
      end
    end else if (bus_rd && bus_addr == 3'd3 && reads_left > 0) begin
      reads_left <= reads_left - 1;
    end
  end

  // ---------- monitor ----------
  logic [2:0] lw_a [0:127];
  logic [7:0] lw_d [0:127];
  logic [7:0] rxb  [0:63];
  int nw, nrx, dcnt, ecnt, post_act;
  bit post;
  logic [CNT_W-1:0] got_len;
  logic [7:0] got_est;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr && nw < 128) begin lw_a[nw] = bus_addr; lw_d[nw] = bus_wdata; nw++; end
      if (rx_valid && nrx < 64) begin rxb[nrx] = rx_data; nrx++; end
      if (done) begin dcnt++; got_len = xfer_len; end
      if (err)  begin ecnt++; got_est = err_stat; end
      if (post && (bus_wr || bus_rd)) post_act++;
    end
  end

  // ---------- expected bus writes ----------
  logic [2:0] ew_a [0:127];
  logic [7:0] ew_d [0:127];
  int ne;

  task automatic push(input logic [2:0] a, input logic [7:0] v);
    ew_a[ne] = a; ew_d[ne] = v; ne++;
  endtask

  task automatic build_exp(input logic [6:0] dv, input logic [15:0] of, input bit wd, input int ce);
    ne = 0;
    push(3'd7, 8'h00); push(3'd0, 8'h00); push(3'd4, 8'h00); push(3'd3, 8'h24);  // R1
    push(3'd2, 8'h40);
    push(3'd2, 8'h60); push(3'd1, {dv, 1'b0}); push(3'd2, 8'h40);              // R2
    if (wd) begin push(3'd1, of[15:8]); push(3'd2, 8'h40); end                  // R3
    push(3'd1, of[7:0]); push(3'd2, 8'h40);
    push(3'd2, 8'h60); push(3'd1, {dv, 1'b1}); push(3'd2, 8'h40);              // R4
    for (int i = 0; i < ce - 1; i++) push(3'd2, 8'h44);                          // R5
    push(3'd2, 8'h40);
    push(3'd2, 8'h50);                                                           // R6
  endtask

  task automatic run(input logic [6:0] dv, input logic [15:0] of, input bit wd, input int cnt,
                     input int lat, input int ia, input logic [7:0] ic,
                     input bit exp_err, input int exp_nw, input logic [7:0] exp_est,
                     input bit mid, input string tag);
    int ce, lim, bad;
    ce = (cnt == 0) ? 1 : cnt;
    cur_off = of; lat_cfg = lat; inj_at = ia; inj_code = ic;
    nw = 0; nrx = 0; dcnt = 0; ecnt = 0; post = 0; post_act = 0;
    build_exp(dv, of, wd, ce);
    @(negedge clk);
    dev_addr = dv; reg_off = of; off_wide = wd; byte_cnt = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dev_addr = ~dv; reg_off = ~of; off_wide = ~wd; byte_cnt = CNT_W'(cnt + 3);  // R9: no effect
    if (mid) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    lim = 0;
    while (dcnt + ecnt == 0 && lim < 20000) begin @(negedge clk); lim++; end
    chk(lim < 20000, {tag, " watchdog"}, lim, 0);
    post = 1;
    repeat (20) @(negedge clk);
    post = 0;
    chk(post_act == 0, {tag, " R8/R9 bus quiet after end"}, post_act, 0);
    if (exp_err) begin
      chk(ecnt == 1 && dcnt == 0, {tag, " R8 err pulse"}, ecnt, 1);
      chk(got_est == exp_est, {tag, " R8 err_stat"}, got_est, exp_est);
      chk(nw == exp_nw, {tag, " R8 writes before abort"}, nw, exp_nw);
    end else begin
      chk(dcnt == 1 && ecnt == 0, {tag, " R6 done pulse"}, dcnt, 1);
      chk(got_len == CNT_W'(ce), {tag, " R6 xfer_len"}, got_len, ce);
      chk(nw == ne, {tag, " R1-chain write count"}, nw, ne);
      chk(nrx == ce, {tag, " R5 byte count"}, nrx, ce);
      bad = 0;
      for (int i = 0; i < nrx && i < ce; i++) if (rxb[i] != pat(of, i)) bad++;
      chk(bad == 0, {tag, " R5 byte values"}, bad, 0);
    end
    bad = 0;
    for (int i = 0; i < nw && i < ne; i++)
      if (lw_a[i] != ew_a[i] || lw_d[i] != ew_d[i]) begin
        if (bad == 0)
          chk(0, {tag, " R1 R2 R3 R4 write sequence"}, {lw_a[i], lw_d[i]}, {ew_a[i], ew_d[i]});
        bad++;
      end
    if (bad == 0) chk(1, {tag, " write sequence"}, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(!busy && !bus_wr && !bus_rd && !done && !err && !rx_valid, "R10 reset state",
        {busy, bus_wr, bus_rd, done, err, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_wr && !bus_rd, "R10 idle quiet", {busy, bus_wr, bus_rd}, 0);

    // directed corners
    run(7'h50, 16'h0012, 1'b0, 1, -1, 0, 8'h00, 0, 0, 8'h00, 0, "single byte");     // R5
    run(7'h51, 16'h0034, 1'b0, 0, -1, 0, 8'h00, 0, 0, 8'h00, 0, "count zero");      // R5
    run(7'h2A, 16'hBEEF, 1'b1, 4, -1, 0, 8'h00, 0, 0, 8'h00, 0, "wide offset");     // R3
    run(7'h13, 16'h1234, 1'b1, 3, TRIES-1, 0, 8'h00, 0, 0, 8'h00, 0, "last try");   // R7
    run(7'h13, 16'h1234, 1'b1, 3, TRIES, 0, 8'h00, 1, 5, 8'h00, 0, "timeout");      // R8
    run(7'h44, 16'h00A0, 1'b0, 2, -1, 3, 8'h20, 1, 8, 8'h20, 0, "addr nack");       // R8
    run(7'h44, 16'h00A0, 1'b0, 2, -1, 6, 8'h48, 1, 13, 8'h48, 0, "read addr nack"); // R8
    run(7'h3C, 16'h5A5A, 1'b1, 5, -1, 0, 8'h00, 0, 0, 8'h00, 1, "start while busy"); // R9

    // random
    for (int k = 0; k < 8; k++) begin
      run(7'($urandom), 16'($urandom), 1'($urandom), int'($urandom_range(1, 6)),
          -1, 0, 8'h00, 0, 0, 8'h00, 0, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule